// File: doc/BRIEF.md
# Repeat-Prefix Instruction Sequencer

This block sits between instruction fetch and the execution unit. It takes a prefix word and the instruction word that follows it. The prefix says how many times the following instruction runs and which of its three address fields move forward by one on each pass. The sequencer then hands the execution unit one derived copy of that instruction per pass. It waits for the execution unit to report completion before it moves to the next pass. The copy held by the caller is never modified. Each issued word is rebuilt from the latched original plus the pass index.

If the prefix names a nonzero destination address, the sequencer first asks the memory port to write zero at that address. It holds the request until the memory port acknowledges, and only then issues anything. If the following word is itself a prefix or a built-in subroutine call, it runs once and no address moves. If the word given as prefix is not a prefix at all, the following instruction also runs once and nothing is cleared.

Instruction layout (43 bits): bit 42 break flag, bits 41:36 opcode, bits 35:24 source address, bits 23:12 operand address, bits 11:0 destination address.

Top module: `rpt_seq`

## Requirements
- R1: After reset is released, busy_o, done_o, clr_req_o and iss_valid_o are all low.
- R2: A word whose opcode bits 41:39 equal 3'b011 is a prefix. Its operand field (bits 23:12) holds a count N, and the following instruction is issued N+1 times.
- R3: On pass k (starting at 0), each address field whose enable bit is set carries its original value plus k. Opcode bit 38 enables the source field, bit 37 the operand field, bit 36 the destination field. Pass 0 is unmodified.
- R4: Every issued copy keeps the break bit and opcode of the following instruction, and address fields that are not enabled keep their original values.
- R5: When the prefix destination field (bits 11:0) is nonzero, clr_req_o rises with clr_addr_o equal to that field before any issue. It stays high with a stable address until clr_ack_i is seen, and no issue occurs meanwhile.
- R6: When the prefix destination field is zero, clr_req_o never rises for that operation.
- R7: A pass ends only on a cycle with exec_done_i high. Until then iss_valid_o stays high and iss_instr_o stays unchanged.
- R8: done_o is high for exactly one cycle, in the cycle after the exec_done_i that ends the final pass. busy_o is low in that cycle.
- R9: If the following instruction's opcode has bits 41:39 equal to 3'b011 or bits 41:40 equal to 2'b11, it is issued exactly once and unmodified, whatever the count.
- R10: If the word given on pfx_i is not a prefix, the following instruction is issued once unmodified and no clear is requested.
- R11: start_i is ignored while an operation is in progress, and the running sequence is not altered by it.
- R12: Incremented address fields wrap modulo 4096.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Accept pfx_i and nxt_i when idle |
| pfx_i | input | 43 | Prefix word |
| nxt_i | input | 43 | Instruction following the prefix |
| clr_req_o | output | 1 | Request to write zero to memory |
| clr_addr_o | output | 12 | Address to clear |
| clr_ack_i | input | 1 | Memory write acknowledge |
| iss_valid_o | output | 1 | Issued instruction valid |
| iss_instr_o | output | 43 | Effective instruction for this pass |
| exec_done_i | input | 1 | Execution unit finished current pass |
| busy_o | output | 1 | Clear or issue in progress |
| done_o | output | 1 | One-cycle completion pulse |

## Verification
The main sweep covers all eight field-enable patterns, counts 0 through 3, and both a zero and a nonzero clear address. This separates a wrong bit-to-field mapping, an off-by-one pass count, and a clear issued at the wrong time. The operand field of the following word starts at 4094, so later passes cross the wrap point. Varying the acknowledge and execution delays shows whether the request and the issued word are held steady while the block waits. Separate runs pair a prefix with a nested prefix, with a subroutine call, and with a non-prefix word. A start pulse in the middle of a run shows whether a busy sequencer can be disturbed.

// File: rtl/rpt_pkg.sv
package rpt_pkg;
  parameter int AW  = 12;
  parameter int OPW = 6;
  localparam int NF      = 3;
  localparam int IW      = 1 + OPW + NF * AW;
  localparam int DST_LSB = 0;
  localparam int OPD_LSB = AW;
  localparam int SRC_LSB = 2 * AW;
  localparam int OPC_LSB = NF * AW;
  localparam int BRK_BIT = IW - 1;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_CLR  = 2'd1,
    ST_ISS  = 2'd2,
    ST_FIN  = 2'd3
  } st_e;
endpackage

// File: rtl/rpt_decode.sv
module rpt_decode
  import rpt_pkg::*;
(
  input  logic [IW-1:0] pfx_i,
  input  logic [IW-1:0] nxt_i,
  output logic [AW-1:0] cnt_o,
  output logic [NF-1:0] msk_o,
  output logic          clr_en_o,
  output logic [AW-1:0] clr_addr_o
);
  logic [OPW-1:0] p_op, n_op;
  logic           is_pfx, nxt_single, rep;
  logic           unused_pfx;

  assign p_op       = pfx_i[OPC_LSB +: OPW];
  assign n_op       = nxt_i[OPC_LSB +: OPW];
  assign is_pfx     = p_op[OPW-1 -: 3] == 3'b011;
  // nested prefix or built-in subroutine runs once
  assign nxt_single = (n_op[OPW-1 -: 3] == 3'b011) || (n_op[OPW-1 -: 2] == 2'b11);
  assign rep        = is_pfx && !nxt_single;

  assign cnt_o      = rep ? pfx_i[OPD_LSB +: AW] : '0;
  assign msk_o      = rep ? p_op[NF-1:0] : '0;
  assign clr_addr_o = pfx_i[DST_LSB +: AW];
  assign clr_en_o   = is_pfx && (clr_addr_o != '0);

  assign unused_pfx = ^{pfx_i[BRK_BIT], pfx_i[SRC_LSB +: AW], nxt_i[BRK_BIT], nxt_i[NF*AW-1:0],
                        n_op[OPW-3:0]};
endmodule

// File: rtl/rpt_addr_step.sv
module rpt_addr_step
  import rpt_pkg::*;
(
  input  logic [IW-1:0] base_i,
  input  logic [AW-1:0] iter_i,
  input  logic [NF-1:0] msk_i,
  output logic [IW-1:0] eff_o
);
  // mask bit g steps field g: 0 dst, 1 opd, 2 src
  for (genvar g = 0; g < NF; g++) begin : g_fld
    assign eff_o[g*AW +: AW] = base_i[g*AW +: AW] + (msk_i[g] ? iter_i : '0);
  end
  assign eff_o[IW-1:NF*AW] = base_i[IW-1:NF*AW];
endmodule

// File: rtl/rpt_fsm.sv
module rpt_fsm
  import rpt_pkg::*;
(
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic          clr_en_i,
  input  logic [AW-1:0] cnt_i,
  input  logic          clr_ack_i,
  input  logic          exec_done_i,
  output st_e           st_o,
  output logic [AW-1:0] iter_o,
  output logic          cap_o
);
  st_e           st_q;
  logic [AW-1:0] iter_q;

  assign cap_o  = (st_q == ST_IDLE) && start_i;
  assign st_o   = st_q;
  assign iter_o = iter_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_IDLE;
      iter_q <= '0;
    end else begin
      unique case (st_q)
        ST_IDLE: if (start_i) begin
          st_q   <= clr_en_i ? ST_CLR : ST_ISS;
          iter_q <= '0;
        end
        ST_CLR:  if (clr_ack_i) st_q <= ST_ISS;
        ST_ISS:  if (exec_done_i) begin
          if (iter_q == cnt_i) st_q <= ST_FIN;
          else iter_q <= AW'(iter_q + 1'b1);
        end
        ST_FIN:  st_q <= ST_IDLE;
        default: st_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/rpt_seq.sv
module rpt_seq
  import rpt_pkg::*;
(
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic [42:0]   pfx_i,
  input  logic [42:0]   nxt_i,
  output logic          clr_req_o,
  output logic [11:0]   clr_addr_o,
  input  logic          clr_ack_i,
  output logic          iss_valid_o,
  output logic [42:0]   iss_instr_o,
  input  logic          exec_done_i,
  output logic          busy_o,
  output logic          done_o
);
  logic [AW-1:0] d_cnt, d_clr_addr, cnt_q, clr_addr_q, iter;
  logic [NF-1:0] d_msk, msk_q;
  logic          d_clr_en, cap;
  logic [IW-1:0] nxt_q;
  st_e           st;

  rpt_decode u_dec (
    .pfx_i      (pfx_i),
    .nxt_i      (nxt_i),
    .cnt_o      (d_cnt),
    .msk_o      (d_msk),
    .clr_en_o   (d_clr_en),
    .clr_addr_o (d_clr_addr)
  );

  rpt_fsm u_fsm (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .start_i     (start_i),
    .clr_en_i    (d_clr_en),
    .cnt_i       (cnt_q),
    .clr_ack_i   (clr_ack_i),
    .exec_done_i (exec_done_i),
    .st_o        (st),
    .iter_o      (iter),
    .cap_o       (cap)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q      <= '0;
      msk_q      <= '0;
      clr_addr_q <= '0;
      nxt_q      <= '0;
    end else if (cap) begin
      cnt_q      <= d_cnt;
      msk_q      <= d_msk;
      clr_addr_q <= d_clr_addr;
      nxt_q      <= nxt_i;
    end
  end

  rpt_addr_step u_step (
    .base_i (nxt_q),
    .iter_i (iter),
    .msk_i  (msk_q),
    .eff_o  (iss_instr_o)
  );

  assign clr_req_o   = st == ST_CLR;
  assign clr_addr_o  = clr_addr_q;
  assign iss_valid_o = st == ST_ISS;
  assign busy_o      = (st == ST_CLR) || (st == ST_ISS);
  assign done_o      = st == ST_FIN;
endmodule

// File: rtl/rpt_seq_chk.sv
module rpt_seq_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        start_i,
  input logic [42:0] pfx_i,
  input logic [42:0] nxt_i,
  input logic        clr_req_o,
  input logic [11:0] clr_addr_o,
  input logic        clr_ack_i,
  input logic        iss_valid_o,
  input logic [42:0] iss_instr_o,
  input logic        exec_done_i,
  input logic        busy_o,
  input logic        done_o
);
  logic unused_chk;
  assign unused_chk = ^{start_i, pfx_i, nxt_i};

  AST_CLR_NO_ISS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(clr_req_o && iss_valid_o)); // R5
  AST_CLR_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_req_o && !clr_ack_i |=> clr_req_o && $stable(clr_addr_o)); // R5
  AST_CLR_NONZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_req_o |-> clr_addr_o != 12'd0); // R6
  AST_ISS_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    iss_valid_o && !exec_done_i |=> iss_valid_o && $stable(iss_instr_o)); // R7
  AST_OPC_KEEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    iss_valid_o && $past(iss_valid_o) |-> iss_instr_o[42:36] == $past(iss_instr_o[42:36])); // R4
  AST_DONE_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o); // R8
  AST_DONE_AFTER_EXEC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> $past(exec_done_i) && $past(iss_valid_o) && !busy_o); // R8
  AST_IDLE_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> !iss_valid_o && !clr_req_o); // R1
endmodule

bind rpt_seq rpt_seq_chk u_chk (.*);

// File: tb/rpt_seq_test.sv
`timescale 1ns/1ps
module rpt_seq_test;
  logic        clk_i = 1'b0, rst_ni = 1'b0, start_i = 1'b0;
  logic [42:0] pfx_i = '0, nxt_i = '0;
  logic        clr_ack_i = 1'b0, exec_done_i = 1'b0;
  logic        clr_req_o, iss_valid_o, busy_o, done_o;
  logic [11:0] clr_addr_o;
  logic [42:0] iss_instr_o;
  int total = 0, bad = 0, cyc = 0;
  bit finished = 0;

  always #10 clk_i = ~clk_i;

  rpt_seq uut (.*);

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  function automatic logic [42:0] exp_word(input logic [42:0] p, input logic [42:0] n, input int k);
    logic [5:0]  po, no;
    logic [2:0]  m;
    logic [42:0] e;
    po = p[41:36]; no = n[41:36];
    m  = (po[5:3] == 3'b011 && !(no[5:3] == 3'b011 || no[5:4] == 2'b11)) ? po[2:0] : 3'b000;
    e  = n;
    if (m[2]) e[35:24] = 12'(n[35:24] + k);
    if (m[1]) e[23:12] = 12'(n[23:12] + k);
    if (m[0]) e[11:0]  = 12'(n[11:0] + k);
    return e;
  endfunction

  task automatic run_op(input logic [42:0] p, input logic [42:0] n, input int ackd, input int exd,
                        input bit poke, input string tag);
    bit ispf, single, clr;
    int cnt;
    logic [42:0] e;
    ispf   = p[41:39] == 3'b011;
    single = (n[41:39] == 3'b011) || (n[41:40] == 2'b11);
    cnt    = (ispf && !single) ? int'(p[23:12]) : 0;
    clr    = ispf && (p[11:0] != 12'd0);
    @(negedge clk_i);
    pfx_i = p; nxt_i = n; start_i = 1'b1;
    @(negedge clk_i);
    start_i = 1'b0; pfx_i = '0; nxt_i = '0;
    if (clr) begin
      check(clr_req_o && !iss_valid_o && clr_addr_o == p[11:0], "R5 clear first",
            {clr_req_o, iss_valid_o, clr_addr_o}, {2'b10, p[11:0]});
      for (int i = 0; i < ackd; i++) begin
        @(negedge clk_i);
        check(clr_req_o && !iss_valid_o && clr_addr_o == p[11:0], "R5 hold",
              {clr_req_o, iss_valid_o, clr_addr_o}, {2'b10, p[11:0]});
      end
      clr_ack_i = 1'b1;
      @(negedge clk_i);
      clr_ack_i = 1'b0;
    end else begin
      check(!clr_req_o, ispf ? "R6 no clear" : "R10 no clear", clr_req_o, 0);
    end
    for (int k = 0; k <= cnt; k++) begin
      e = exp_word(p, n, k);
      check(iss_valid_o && iss_instr_o == e, tag, iss_instr_o, e);
      check(iss_instr_o[42:36] == n[42:36], "R4 brk/opc", iss_instr_o[42:36], n[42:36]);
      for (int i = 0; i < exd; i++) begin
        if (poke && k == 0 && i == 0) begin
          pfx_i = 43'h0E_0000_0005; nxt_i = 43'h7FF_FFFF_FFFF; start_i = 1'b1;
        end
        @(negedge clk_i);
        start_i = 1'b0;
        check(iss_valid_o && iss_instr_o == e, poke ? "R11 busy start" : "R7 wait",
              iss_instr_o, e);
      end
      exec_done_i = 1'b1;
      @(negedge clk_i);
      exec_done_i = 1'b0;
    end
    check(done_o && !busy_o && !iss_valid_o, "R8 R2 done after last",
          {done_o, busy_o, iss_valid_o}, 3'b100);
    @(negedge clk_i);
    check(!done_o && !busy_o, "R8 pulse", {done_o, busy_o}, 2'b00);
  endtask

  initial begin
    while (!finished) begin
      @(posedge clk_i);
      cyc++;
      if (cyc > 100000) begin
        bad++; total++;
        $display("FAIL watchdog act=%0d exp<100000", cyc);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
      end
    end
  end

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    check(!busy_o && !done_o && !clr_req_o && !iss_valid_o, "R1 reset",
          {busy_o, done_o, clr_req_o, iss_valid_o}, 4'b0);
    // R2 R3 R12 sweep: opd base 4094 crosses wrap
    for (int m = 0; m < 8; m++)
      for (int c = 0; c < 4; c++)
        for (int z = 0; z < 2; z++)
          run_op({1'b0, 3'b011, 3'(m), 12'h123, 12'(c), (z != 0) ? 12'(12'h800 + m) : 12'h000},
                 {1'(m), 6'b000001, 12'hFFF, 12'hFFE, 12'(12'h010 + c)},
                 m % 3, c % 3, 1'b0, "R2 R3 R12 pass");
    // R9 nested prefix and subroutine
    run_op({1'b0, 6'b011111, 12'h0, 12'd5, 12'h0}, {1'b0, 6'b011010, 12'h1, 12'h2, 12'h3},
           0, 1, 1'b0, "R9 nested prefix");
    run_op({1'b0, 6'b011111, 12'h0, 12'd5, 12'h044}, {1'b1, 6'b110111, 12'h4, 12'h5, 12'h6},
           1, 0, 1'b0, "R9 subroutine");
    // R10 non-prefix
    run_op({1'b0, 6'b000101, 12'h7, 12'd9, 12'h0AA}, {1'b0, 6'b001001, 12'h8, 12'h9, 12'hA},
           0, 1, 1'b0, "R10 non-prefix");
    // R11 start while busy
    run_op({1'b0, 6'b011101, 12'h0, 12'd2, 12'h0}, {1'b0, 6'b000011, 12'h20, 12'h30, 12'h40},
           0, 2, 1'b1, "R11 R3 pass");
    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule